// File: doc/BRIEF.md
# MSI Receive Status Aggregator

This block sits at a root port and records message-signalled interrupts as they arrive. Each arrival carries a message number, and the block sets the matching bit in a sticky per-vector status register. The same arrival also sets one summary bit in a local interrupt status register. The other bits of that local register are set by pulses on a parameterised group of source pins. The block drives a level interrupt towards the processor while any local status bit is set.

Software reads both registers through a small register port. It clears bits by writing ones, and a write of zero leaves a bit as it is. The two registers are cleared independently. A handler can clear the summary bit first, then read the vector register, then clear the vector bits it read. Any vector bit that arrives during that sequence stays pending. Any arrival also sets the summary bit again, so the interrupt line does not drop while work is outstanding.

Top module: `msi_stat_agg`

## Requirements
- R1: While reset is asserted and on its release, both status registers read zero and `irq` is low.
- R2: A cycle with `msi_valid` high and `msi_num` = n sets bit n of the vector status register (address 1) at the next clock edge. The bit stays set until software clears it.
- R3: A cycle with `msi_valid` high sets bit 28 (the summary bit) of the local status register (address 0) at the next clock edge.
- R4: A high level on `src_pulse[k]` sets bit k of the local status register at the next clock edge. Sources are independent, and several may set their bits in the same cycle.
- R5: A write with `reg_wr` high clears every bit of the addressed register whose `reg_wdata` bit is 1. Bits written with 0 keep their value.
- R6: When a hardware set and a software clear hit the same bit in the same cycle, the bit ends up set. This holds for both registers.
- R7: `irq` is high exactly while at least one bit of the local status register is set.
- R8: Clearing the summary bit leaves the vector status register unchanged. A new arrival sets the summary bit again even while older vector bits are still pending.
- R9: `reg_rdata` shows the local register at address 0 and the vector register at address 1. Addresses 2 and 3 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | One-cycle MSI arrival strobe |
| msi_num | input | 5 | Message number of the arrival |
| src_pulse | input | 4 | Set pulses for the other local sources (bits 0..3) |
| reg_wr | input | 1 | Write-one-to-clear strobe |
| reg_addr | input | 2 | Register select (0 local, 1 vector) |
| reg_wdata | input | 32 | Clear mask |
| reg_rdata | output | 32 | Combinational read of the selected register |
| irq | output | 1 | Level interrupt to the processor |

## Verification
Single arrivals at vector 0, vector 31 and an interior vector show that the number decodes to the right bit position. Simultaneous pulses on several sources show that the sources are independent. A set and a clear aimed at the same bit in the same cycle, in each register, separate set-wins behaviour from clear-wins behaviour. The sequence clear summary, read vectors, new arrival, clear the read vectors is the lost-event case: the late vector must survive and the summary must return. A long stretch of random arrivals, pulses and writes to all four addresses is then compared against a behavioural model on every clock.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
   localparam int unsigned REG_W  = 32;
   localparam int unsigned ADDR_W = 2;
   typedef logic [ADDR_W-1:0] reg_addr_t;
   localparam reg_addr_t ADDR_LOCAL = 2'd0;
   localparam reg_addr_t ADDR_VEC   = 2'd1;
endpackage

// File: rtl/w1c_status_reg.sv
module w1c_status_reg #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] q
);
   generate
      if (W < 1) begin : g_bad_width
         $error("w1c_status_reg: W must be at least 1");
      end
   endgenerate

   logic [W-1:0] q_next;

   always_comb begin
      q_next = (q & ~clr_i) | set_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else        q <= q_next;
   end

   assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((q & $past(set_i)) == $past(set_i)));

   assert_clear_takes_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(clr_i) & ~$past(set_i) & q) == '0));

   assert_untouched_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((q ^ $past(q)) & ~($past(set_i) | $past(clr_i))) == '0));
endmodule

// File: rtl/msi_vec_decode.sv
module msi_vec_decode #(
   parameter int unsigned NUM_VEC = 32,
   localparam int unsigned VEC_W  = $clog2(NUM_VEC)
) (
   input  logic               valid_i,
   input  logic [VEC_W-1:0]   num_i,
   output logic [NUM_VEC-1:0] hit_o
);
   generate
      for (genvar i = 0; i < NUM_VEC; i++) begin : g_bit
         assign hit_o[i] = valid_i && (num_i == VEC_W'(i));
      end
   endgenerate

   always_comb begin
      if (!valid_i) assert_no_hit_idle_R2: assert (hit_o == '0);
   end
endmodule

// File: rtl/local_set_map.sv
module local_set_map #(
   parameter int unsigned REG_W       = 32,
   parameter int unsigned NUM_SRC     = 4,
   parameter int unsigned SUMMARY_BIT = 28
) (
   input  logic               msi_valid_i,
   input  logic [NUM_SRC-1:0] src_i,
   output logic [REG_W-1:0]   set_o
);
   generate
      for (genvar b = 0; b < REG_W; b++) begin : g_lbit
         if (b == SUMMARY_BIT) begin : g_summary
            assign set_o[b] = msi_valid_i;
         end else if (b < NUM_SRC) begin : g_source
            assign set_o[b] = src_i[b];
         end else begin : g_unused
            assign set_o[b] = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/msi_agg_regif.sv
module msi_agg_regif
   import msi_agg_pkg::*;
#(
   parameter int unsigned NUM_VEC = 32
) (
   input  logic               wr_i,
   input  reg_addr_t          addr_i,
   input  logic [REG_W-1:0]   wdata_i,
   input  logic [REG_W-1:0]   local_q_i,
   input  logic [NUM_VEC-1:0] vec_q_i,
   output logic [REG_W-1:0]   clr_local_o,
   output logic [NUM_VEC-1:0] clr_vec_o,
   output logic [REG_W-1:0]   rdata_o
);
   logic [REG_W-1:0] vec_wide;
   logic             sel_local;
   logic             sel_vec;

   generate
      if (NUM_VEC == REG_W) begin : g_full
         assign vec_wide = vec_q_i;
         assign clr_vec_o = (wr_i && sel_vec) ? wdata_i : '0;
      end else begin : g_narrow
         logic [REG_W-NUM_VEC-1:0] wdata_hi_unused;
         assign vec_wide = {{(REG_W-NUM_VEC){1'b0}}, vec_q_i};
         assign clr_vec_o = (wr_i && sel_vec) ? wdata_i[NUM_VEC-1:0] : '0;
         assign wdata_hi_unused = wdata_i[REG_W-1:NUM_VEC];
      end
   endgenerate

   assign sel_local   = (addr_i == ADDR_LOCAL);
   assign sel_vec     = (addr_i == ADDR_VEC);
   assign clr_local_o = (wr_i && sel_local) ? wdata_i : '0;

   always_comb begin
      if (sel_local)    rdata_o = local_q_i;
      else if (sel_vec) rdata_o = vec_wide;
      else              rdata_o = '0;
   end

   always_comb begin
      assert_one_target_R9: assert (!((clr_local_o != '0) && (clr_vec_o != '0)));
   end
endmodule

// File: rtl/msi_stat_agg.sv
module msi_stat_agg
   import msi_agg_pkg::*;
#(
   parameter int unsigned NUM_VEC     = 32,
   parameter int unsigned NUM_SRC     = 4,
   parameter int unsigned SUMMARY_BIT = 28,
   localparam int unsigned VEC_W      = $clog2(NUM_VEC)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      msi_valid,
   input  logic [VEC_W-1:0]          msi_num,
   input  logic [NUM_SRC-1:0]        src_pulse,
   input  logic                      reg_wr,
   input  logic [ADDR_W-1:0]         reg_addr,
   input  logic [REG_W-1:0]          reg_wdata,
   output logic [REG_W-1:0]          reg_rdata,
   output logic                      irq
);
   generate
      if (NUM_VEC < 2 || NUM_VEC > REG_W) begin : g_bad_vec
         $error("msi_stat_agg: NUM_VEC must lie in 2..REG_W");
      end
      if (SUMMARY_BIT >= REG_W) begin : g_bad_summary
         $error("msi_stat_agg: SUMMARY_BIT outside the local register");
      end
      if (NUM_SRC < 1 || NUM_SRC > SUMMARY_BIT) begin : g_bad_src
         $error("msi_stat_agg: sources must fit below the summary bit");
      end
   endgenerate

   logic [NUM_VEC-1:0] vec_set;
   logic [NUM_VEC-1:0] vec_clr;
   logic [NUM_VEC-1:0] vec_q;
   logic [REG_W-1:0]   loc_set;
   logic [REG_W-1:0]   loc_clr;
   logic [REG_W-1:0]   loc_q;

   msi_vec_decode #(.NUM_VEC(NUM_VEC)) u_dec (
      .valid_i (msi_valid),
      .num_i   (msi_num),
      .hit_o   (vec_set)
   );

   local_set_map #(
      .REG_W       (REG_W),
      .NUM_SRC     (NUM_SRC),
      .SUMMARY_BIT (SUMMARY_BIT)
   ) u_map (
      .msi_valid_i (msi_valid),
      .src_i       (src_pulse),
      .set_o       (loc_set)
   );

   msi_agg_regif #(.NUM_VEC(NUM_VEC)) u_regif (
      .wr_i        (reg_wr),
      .addr_i      (reg_addr),
      .wdata_i     (reg_wdata),
      .local_q_i   (loc_q),
      .vec_q_i     (vec_q),
      .clr_local_o (loc_clr),
      .clr_vec_o   (vec_clr),
      .rdata_o     (reg_rdata)
   );

   w1c_status_reg #(.W(NUM_VEC)) u_vec_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (vec_set),
      .clr_i (vec_clr),
      .q     (vec_q)
   );

   w1c_status_reg #(.W(REG_W)) u_loc_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (loc_set),
      .clr_i (loc_clr),
      .q     (loc_q)
   );

   assign irq = |loc_q;

   assert_vec_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
      msi_valid |=> vec_q[$past(msi_num)]);

   assert_summary_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      msi_valid |=> loc_q[SUMMARY_BIT]);

   assert_src_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (src_pulse != '0) |=> ((loc_q[NUM_SRC-1:0] & $past(src_pulse)) == $past(src_pulse)));

   assert_irq_on_arrival_R7: assert property (@(posedge clk) disable iff (!rst_n)
      msi_valid |=> irq);

   assert_summary_clear_keeps_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_LOCAL) |=> (($past(vec_q) & ~vec_q) == '0));

   assert_bad_addr_inert_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr != ADDR_LOCAL && reg_addr != ADDR_VEC)
         |=> ((($past(loc_q) & ~loc_q) == '0) && (($past(vec_q) & ~vec_q) == '0)));

   assert_reset_clean_R1: assert property (@(posedge clk)
      !rst_n |=> (!rst_n || (vec_q & ~$past(vec_set)) == '0));
endmodule

// File: tb/msi_stat_agg_test.sv
`timescale 1ns/1ps
module msi_stat_agg_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        msi_valid;
   logic [4:0]  msi_num;
   logic [3:0]  src_pulse;
   logic        reg_wr;
   logic [1:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        irq;

   int nchk  = 0;
   int nfail = 0;
   bit done  = 1'b0;

   logic [31:0] exp_local = '0;
   logic [31:0] exp_vec   = '0;

   always #10 clk = ~clk;

   msi_stat_agg uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .msi_valid (msi_valid),
      .msi_num   (msi_num),
      .src_pulse (src_pulse),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] model_read(input logic [1:0] a);
      if (a == 2'd0)      return exp_local;
      else if (a == 2'd1) return exp_vec;
      else                return 32'h0;
   endfunction

   // One clock: drive, compare before the edge, then advance the model.
   task automatic cyc(input logic mv, input logic [4:0] mn, input logic [3:0] sp,
                      input logic wr, input logic [1:0] a, input logic [31:0] wd,
                      input string tag);
      logic [31:0] s_l, s_v, c_l, c_v;
      @(negedge clk);
      msi_valid = mv; msi_num = mn; src_pulse = sp;
      reg_wr = wr; reg_addr = a; reg_wdata = wd;
      #2;
      chk(tag, reg_rdata, model_read(a));
      chk("R7", {31'b0, irq}, {31'b0, exp_local != 32'h0});
      @(posedge clk);
      s_l = {28'b0, sp};
      if (mv) s_l[28] = 1'b1;
      s_v = mv ? (32'h1 << mn) : 32'h0;
      c_l = (wr && a == 2'd0) ? wd : 32'h0;
      c_v = (wr && a == 2'd1) ? wd : 32'h0;
      exp_local = (exp_local & ~c_l) | s_l;
      exp_vec   = (exp_vec & ~c_v) | s_v;
   endtask

   task automatic look(input logic [1:0] a, input string tag);
      cyc(1'b0, 5'd0, 4'd0, 1'b0, a, 32'h0, tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         nfail++;
         nchk++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [31:0] snap;
      rst_n = 1'b0;
      msi_valid = 1'b1; msi_num = 5'd3; src_pulse = 4'hF;
      reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = 32'h0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1", reg_rdata, 32'h0);
      chk("R1", {31'b0, irq}, 32'h0);
      reg_addr = 2'd1;
      #1 chk("R1", reg_rdata, 32'h0);
      msi_valid = 1'b0; src_pulse = 4'h0;
      rst_n = 1'b1;
      look(2'd0, "R1");

      // R2 / R3: vector decode at the ends and inside
      cyc(1'b1, 5'd0,  4'd0, 1'b0, 2'd1, 32'h0, "R2");
      cyc(1'b1, 5'd31, 4'd0, 1'b0, 2'd1, 32'h0, "R2");
      cyc(1'b1, 5'd13, 4'd0, 1'b0, 2'd1, 32'h0, "R2");
      look(2'd1, "R2");
      look(2'd0, "R3");

      // R4: independent, simultaneous sources
      cyc(1'b0, 5'd0, 4'b1010, 1'b0, 2'd0, 32'h0, "R4");
      cyc(1'b0, 5'd0, 4'b0101, 1'b0, 2'd0, 32'h0, "R4");
      look(2'd0, "R4");

      // R5: write ones clears, zeros hold
      cyc(1'b0, 5'd0, 4'd0, 1'b1, 2'd0, 32'h0000_0003, "R5");
      look(2'd0, "R5");
      cyc(1'b0, 5'd0, 4'd0, 1'b1, 2'd1, 32'h0000_0000, "R5");
      look(2'd1, "R5");
      cyc(1'b0, 5'd0, 4'd0, 1'b1, 2'd1, 32'h0000_2000, "R5");
      look(2'd1, "R5");

      // R8: summary clear leaves vectors alone
      cyc(1'b0, 5'd0, 4'd0, 1'b1, 2'd0, 32'h1000_0000, "R8");
      look(2'd1, "R8");
      look(2'd0, "R8");

      // R6: collision in both registers
      cyc(1'b1, 5'd5, 4'd0, 1'b1, 2'd1, 32'h0000_0020, "R6");
      look(2'd1, "R6");
      cyc(1'b0, 5'd0, 4'b0100, 1'b1, 2'd0, 32'h0000_0004, "R6");
      look(2'd0, "R6");
      cyc(1'b1, 5'd6, 4'd0, 1'b1, 2'd0, 32'h1000_0000, "R6");
      look(2'd0, "R6");

      // R8: clear summary, read vectors, late arrival, clear what was read
      cyc(1'b0, 5'd0, 4'd0, 1'b1, 2'd0, 32'h1000_0000, "R8");
      look(2'd1, "R8");
      snap = exp_vec;
      cyc(1'b1, 5'd9, 4'd0, 1'b0, 2'd0, 32'h0, "R8");
      cyc(1'b0, 5'd0, 4'd0, 1'b1, 2'd1, snap, "R8");
      look(2'd1, "R8");
      look(2'd0, "R8");

      // R9: unmapped addresses
      cyc(1'b0, 5'd0, 4'd0, 1'b1, 2'd2, 32'hFFFF_FFFF, "R9");
      cyc(1'b0, 5'd0, 4'd0, 1'b1, 2'd3, 32'hFFFF_FFFF, "R9");
      look(2'd0, "R9");
      look(2'd1, "R9");

      // R7: full clear drops the interrupt
      cyc(1'b0, 5'd0, 4'd0, 1'b1, 2'd1, 32'hFFFF_FFFF, "R7");
      cyc(1'b0, 5'd0, 4'd0, 1'b1, 2'd0, 32'hFFFF_FFFF, "R7");
      look(2'd0, "R7");
      look(2'd1, "R7");

      // mixed traffic against the model
      for (int i = 0; i < 600; i++) begin
         cyc(($urandom % 4) == 0, 5'($urandom), (($urandom % 5) == 0) ? 4'($urandom) : 4'd0,
             ($urandom % 3) == 0, 2'($urandom), $urandom | $urandom, "R5");
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end
endmodule